// File: doc/BRIEF.md
# Interrupt Source Pending Logic

This block holds the per-source state of a message-signalled interrupt domain. For every source it stores a source mode, a pending flag, an enable flag and the raw input level seen in the previous cycle. Each clock cycle counts as one input event: the block compares each raw input against its stored level and sets pending when the mode's edge or level condition holds. The stored level is then updated.

Software reaches the state through two write ports. A mode-write port loads a source's configuration. A strobe port with a source index sets or clears pending or enable. Software pending writes are filtered by the mode: an inactive source ignores them, and a level-mode source accepts a set only while its rectified input is asserted.

The block publishes the pending, enable and rectified-input vectors of all sources. A combinational read port returns one source's state by index. Index 0 and indices at or beyond the source count do not exist. Writes to them do nothing and reads of them return zero.

Top module: `irq_src_bank`

## Requirements
- R1: After reset every source has mode inactive (code 0), and pending, enable, stored input and rectified input are all 0.
- R2: A mode write carries a 4-bit value with the detach flag at bit 3 and the mode at bits 2:0. The mode codes are 0 inactive, 1 detached, 4 rising edge, 5 falling edge, 6 level high and 7 level low; codes 2 and 3 behave as detached. When the detach flag is 1 the stored mode becomes 0. Otherwise bits 2:0 are stored. The new mode takes effect from the next cycle.
- R3: In rising-edge mode, pending becomes 1 at the clock edge where the raw input is 1, the stored input is 0 and pending is 0.
- R4: In falling-edge mode, pending becomes 1 at the clock edge where the raw input is 0, the stored input is 1 and pending is 0.
- R5: In level-high mode pending becomes 1 at any edge with raw input 1. In level-low mode pending becomes 1 at any edge with raw input 0.
- R6: The stored input takes the raw level at every clock edge, in every mode, including inactive and detached.
- R7: The rectified output is the stored input XOR an inversion flag, where the flag is 1 for modes 5 and 7. It is 0 for modes 0 to 3.
- R8: Strobe op codes are 0 set pending, 1 clear pending, 2 set enable and 3 clear enable. Pending set and clear are ignored for an inactive source. In level modes, a pending set is dropped unless the rectified value of the current raw input is 1. Edge and detached modes accept both.
- R9: Index 0 and indices at or beyond NUM_SRC change no state when written. A read of such an index returns mode 0 and pending, enable and rectified values of 0.
- R10: When an input event and a software pending write hit the same source in the same cycle, the input event is applied first and the software write second, so a same-cycle clear wins.
- R11: Set enable makes the source's enable 1 at the next edge, and clear enable makes it 0, in every mode.
- R12: In modes 0 to 3, input activity never sets pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_raw | input | NUM_SRC | Raw input level per source (bit 0 unused) |
| cfg_we | input | 1 | Mode write strobe |
| cfg_idx | input | IDX_W | Source index for the mode write |
| cfg_data | input | 4 | Detach flag (bit 3) and mode code (bits 2:0) |
| sw_valid | input | 1 | Software set/clear strobe |
| sw_op | input | 2 | Strobe operation code |
| sw_idx | input | IDX_W | Source index for the strobe |
| rd_idx | input | IDX_W | Source index for the read port |
| pend_o | output | NUM_SRC | Pending flags |
| en_o | output | NUM_SRC | Enable flags |
| rect_o | output | NUM_SRC | Rectified input values |
| rd_mode | output | 3 | Stored mode of the indexed source |
| rd_pend | output | 1 | Pending of the indexed source |
| rd_en | output | 1 | Enable of the indexed source |
| rd_rect | output | 1 | Rectified input of the indexed source |

## Verification
The directed tests step one source through each mode with held levels, single transitions and a level that returns after a clear. These show edge behaviour apart from level behaviour, and show that the stored input tracks the raw level while the source is detached. Software sets are tried against each mode with the rectified input both asserted and deasserted, which shows where the mode filter applies. Collisions of a clear with an input event in the same cycle show the order in which the two are applied. Random raw toggling, mode rewrites and strobes, including invalid indices, are then compared cycle by cycle with a bench model across all sources at once.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

    localparam int CFG_W      = 4;
    localparam int DETACH_BIT = 3;
    localparam int MODE_W     = 3;

    typedef enum logic [MODE_W-1:0] {
        SM_OFF    = 3'd0,
        SM_DETACH = 3'd1,
        SM_RSV2   = 3'd2,
        SM_RSV3   = 3'd3,
        SM_RISE   = 3'd4,
        SM_FALL   = 3'd5,
        SM_HIGH   = 3'd6,
        SM_LOW    = 3'd7
    } src_mode_e;

    typedef enum logic [1:0] {
        OP_PEND_SET = 2'd0,
        OP_PEND_CLR = 2'd1,
        OP_EN_SET   = 2'd2,
        OP_EN_CLR   = 2'd3
    } sw_op_e;

    typedef struct packed {
        logic      pend;
        logic      en;
        logic      lvl;
        src_mode_e mode;
    } src_state_t;

    function automatic logic mode_is_edge(src_mode_e m);
        return (m == SM_RISE) || (m == SM_FALL);
    endfunction

    function automatic logic mode_is_level(src_mode_e m);
        return (m == SM_HIGH) || (m == SM_LOW);
    endfunction

    function automatic logic mode_is_live(src_mode_e m);
        return mode_is_edge(m) || mode_is_level(m);
    endfunction

    function automatic logic mode_inverts(src_mode_e m);
        return (m == SM_FALL) || (m == SM_LOW);
    endfunction

    // Rectified view of a level under a mode; non-live modes read 0.
    function automatic logic rectify(src_mode_e m, logic lvl);
        return mode_is_live(m) ? (lvl ^ mode_inverts(m)) : 1'b0;
    endfunction

    // Hardware pending condition for one input event.
    function automatic logic hw_sets(src_mode_e m, logic raw, logic prev, logic pend);
        logic hit;
        case (m)
            SM_RISE: hit = raw && !prev;
            SM_FALL: hit = !raw && prev;
            SM_HIGH: hit = raw;
            SM_LOW:  hit = !raw;
            default: hit = 1'b0;
        endcase
        return hit && !pend;
    endfunction

    function automatic src_mode_e cfg_decode(logic [CFG_W-1:0] d);
        return d[DETACH_BIT] ? SM_OFF : src_mode_e'(d[MODE_W-1:0]);
    endfunction

endpackage

// File: rtl/irq_src_decode.sv
module irq_src_decode #(
    parameter int NUM_SRC = 6,
    parameter int IDX_W   = 3
) (
    input  logic               valid,
    input  logic [IDX_W-1:0]   idx,
    output logic [NUM_SRC-1:0] hit
);
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            hit[i] = valid && (i != 0) && (idx == IDX_W'(i));
        end
    end
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_src_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             raw_i,
    input  logic             cfg_hit,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             sw_hit,
    input  sw_op_e           sw_op,
    output src_state_t       st_o,
    output logic             rect_o
);
    src_state_t st_q;
    src_state_t st_d;
    logic       sw_set_ok;

    // Level modes accept a software set only while the rectified raw input is high.
    assign sw_set_ok = (st_q.mode != SM_OFF) &&
                       (!mode_is_level(st_q.mode) || rectify(st_q.mode, raw_i));

    always_comb begin
        st_d = st_q;
        // input event first
        if (hw_sets(st_q.mode, raw_i, st_q.lvl, st_q.pend)) begin
            st_d.pend = 1'b1;
        end
        st_d.lvl = raw_i;
        // software write second
        if (sw_hit) begin
            case (sw_op)
                OP_PEND_SET: if (sw_set_ok) st_d.pend = 1'b1;
                OP_PEND_CLR: if (st_q.mode != SM_OFF) st_d.pend = 1'b0;
                OP_EN_SET:   st_d.en = 1'b1;
                OP_EN_CLR:   st_d.en = 1'b0;
                default:     st_d.en = st_q.en;
            endcase
        end
        if (cfg_hit) begin
            st_d.mode = cfg_decode(cfg_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_o   = st_q;
    assign rect_o = rectify(st_q.mode, st_q.lvl);
endmodule

// File: rtl/irq_src_rdmux.sv
module irq_src_rdmux
    import irq_src_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int IDX_W   = 3
) (
    input  logic [IDX_W-1:0]               rd_idx,
    input  logic [NUM_SRC-1:0]             pend_v,
    input  logic [NUM_SRC-1:0]             en_v,
    input  logic [NUM_SRC-1:0]             rect_v,
    input  logic [NUM_SRC-1:0][MODE_W-1:0] mode_v,
    output logic [MODE_W-1:0]              rd_mode,
    output logic                           rd_pend,
    output logic                           rd_en,
    output logic                           rd_rect
);
    always_comb begin
        rd_mode = '0;
        rd_pend = 1'b0;
        rd_en   = 1'b0;
        rd_rect = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_mode = mode_v[i];
                rd_pend = pend_v[i];
                rd_en   = en_v[i];
                rd_rect = rect_v[i];
            end
        end
    end
endmodule

// File: rtl/irq_src_bank.sv
module irq_src_bank
    import irq_src_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_raw,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [3:0]         cfg_data,
    input  logic               sw_valid,
    input  logic [1:0]         sw_op,
    input  logic [IDX_W-1:0]   sw_idx,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [NUM_SRC-1:0] pend_o,
    output logic [NUM_SRC-1:0] en_o,
    output logic [NUM_SRC-1:0] rect_o,
    output logic [2:0]         rd_mode,
    output logic               rd_pend,
    output logic               rd_en,
    output logic               rd_rect
);
    logic [NUM_SRC-1:0]             cfg_hit;
    logic [NUM_SRC-1:0]             sw_hit;
    logic [NUM_SRC-1:0][MODE_W-1:0] mode_vec;
    src_state_t                     st [NUM_SRC];

    irq_src_decode #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_cfg_dec (
        .valid (cfg_we),
        .idx   (cfg_idx),
        .hit   (cfg_hit)
    );

    irq_src_decode #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_sw_dec (
        .valid (sw_valid),
        .idx   (sw_idx),
        .hit   (sw_hit)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (i == 0) begin : g_none
            assign st[i]     = '0;
            assign rect_o[i] = 1'b0;
        end else begin : g_cell
            irq_src_cell u_cell (
                .clk      (clk),
                .rst      (rst),
                .raw_i    (src_raw[i]),
                .cfg_hit  (cfg_hit[i]),
                .cfg_data (cfg_data),
                .sw_hit   (sw_hit[i]),
                .sw_op    (sw_op_e'(sw_op)),
                .st_o     (st[i]),
                .rect_o   (rect_o[i])
            );
        end
        assign pend_o[i]   = st[i].pend;
        assign en_o[i]     = st[i].en;
        assign mode_vec[i] = st[i].mode;
    end

    irq_src_rdmux #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_rd (
        .rd_idx  (rd_idx),
        .pend_v  (pend_o),
        .en_v    (en_o),
        .rect_v  (rect_o),
        .mode_v  (mode_vec),
        .rd_mode (rd_mode),
        .rd_pend (rd_pend),
        .rd_en   (rd_en),
        .rd_rect (rd_rect)
    );
endmodule

// File: rtl/irq_src_bank_chk.sv
module irq_src_bank_chk #(
    parameter int NUM_SRC = 6,
    parameter int IDX_W   = 3
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_SRC-1:0]        src_raw,
    input logic                      sw_valid,
    input logic [1:0]                sw_op,
    input logic [IDX_W-1:0]          sw_idx,
    input logic [IDX_W-1:0]          rd_idx,
    input logic [NUM_SRC-1:0]        pend_o,
    input logic [NUM_SRC-1:0]        en_o,
    input logic [NUM_SRC-1:0]        rect_o,
    input logic [NUM_SRC-1:0][2:0]   mode_vec,
    input logic [2:0]                rd_mode,
    input logic                      rd_pend,
    input logic                      rd_en,
    input logic                      rd_rect
);
    logic [NUM_SRC-1:0] hit;
    logic               rd_bad;

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            hit[i] = sw_valid && (sw_idx == IDX_W'(i));
        end
    end

    assign rd_bad = (rd_idx == '0) || (int'(rd_idx) >= NUM_SRC);

    // R9
    rd_invalid_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rd_bad |-> (rd_mode == 3'd0 && !rd_pend && !rd_en && !rd_rect));

    for (genvar i = 1; i < NUM_SRC; i++) begin : g_chk
        // R12
        quiet_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (mode_vec[i] < 3'd4 && !hit[i]) |=> $stable(pend_o[i]));

        // R11
        en_set_chk: assert property (@(posedge clk) disable iff (rst)
            (hit[i] && sw_op == 2'd2) |=> en_o[i]);

        // R3
        rise_set_chk: assert property (@(posedge clk) disable iff (rst)
            (mode_vec[i] == 3'd4 && !hit[i] && !pend_o[i] && !rect_o[i] && src_raw[i])
            |=> pend_o[i]);

        // R7
        rect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            (mode_vec[i] < 3'd4) |-> !rect_o[i]);
    end
endmodule

bind irq_src_bank irq_src_bank_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) chk_i (.*);

// File: tb/irq_src_bank_tb_top.sv
module irq_src_bank_tb_top;
    localparam int NS = 6;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_raw = '0;
    logic          cfg_we = 1'b0;
    logic [IW-1:0] cfg_idx = '0;
    logic [3:0]    cfg_data = '0;
    logic          sw_valid = 1'b0;
    logic [1:0]    sw_op = '0;
    logic [IW-1:0] sw_idx = '0;
    logic [IW-1:0] rd_idx = '0;
    logic [NS-1:0] pend_o, en_o, rect_o;
    logic [2:0]    rd_mode;
    logic          rd_pend, rd_en, rd_rect;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    logic [2:0] m_mode [NS];
    bit         m_pend [NS];
    bit         m_en   [NS];
    bit         m_in   [NS];

    always #5 clk = ~clk;

    irq_src_bank #(.NUM_SRC(NS), .IDX_W(IW)) dut_i (
        .clk(clk), .rst(rst), .src_raw(src_raw),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .sw_valid(sw_valid), .sw_op(sw_op), .sw_idx(sw_idx),
        .rd_idx(rd_idx), .pend_o(pend_o), .en_o(en_o), .rect_o(rect_o),
        .rd_mode(rd_mode), .rd_pend(rd_pend), .rd_en(rd_en), .rd_rect(rd_rect)
    );

    function automatic bit f_live(logic [2:0] m);  return m >= 3'd4; endfunction
    function automatic bit f_level(logic [2:0] m); return m >= 3'd6; endfunction
    function automatic bit f_rect(logic [2:0] m, bit l);
        if (!f_live(m)) return 1'b0;
        return l ^ ((m == 3'd5) || (m == 3'd7));
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NS; i++) begin
            m_mode[i] = 3'd0; m_pend[i] = 0; m_en[i] = 0; m_in[i] = 0;
        end
    endtask

    task automatic model_step();
        for (int i = 1; i < NS; i++) begin
            bit p = m_pend[i];
            bit r = src_raw[i];
            case (m_mode[i])
                3'd4: if (r && !m_in[i]) p = 1;
                3'd5: if (!r && m_in[i]) p = 1;
                3'd6: if (r) p = 1;
                3'd7: if (!r) p = 1;
                default: ;
            endcase
            if (sw_valid && int'(sw_idx) == i) begin
                case (sw_op)
                    2'd0: if (m_mode[i] != 0 && (!f_level(m_mode[i]) || f_rect(m_mode[i], r))) p = 1;
                    2'd1: if (m_mode[i] != 0) p = 0;
                    2'd2: m_en[i] = 1;
                    default: m_en[i] = 0;
                endcase
            end
            m_pend[i] = p;
            m_in[i]   = r;
            if (cfg_we && int'(cfg_idx) == i) m_mode[i] = cfg_data[3] ? 3'd0 : cfg_data[2:0];
        end
    endtask

    task automatic compare_model(string tag);
        logic [NS-1:0] ep, ee, er;
        logic [2:0] emode;
        bit ep1, ee1, er1;
        for (int i = 0; i < NS; i++) begin
            ep[i] = m_pend[i]; ee[i] = m_en[i]; er[i] = f_rect(m_mode[i], m_in[i]);
        end
        chk(pend_o == ep && en_o == ee && rect_o == er, tag,
            {pend_o, en_o, rect_o}, {ep, ee, er});
        if (rd_idx != 0 && int'(rd_idx) < NS) begin
            emode = m_mode[rd_idx]; ep1 = m_pend[rd_idx]; ee1 = m_en[rd_idx];
            er1 = f_rect(m_mode[rd_idx], m_in[rd_idx]);
        end else begin
            emode = 0; ep1 = 0; ee1 = 0; er1 = 0;
        end
        chk(rd_mode == emode && rd_pend == ep1 && rd_en == ee1 && rd_rect == er1,
            {tag, " R9 read port"}, {rd_mode, rd_pend, rd_en, rd_rect}, {emode, ep1, ee1, er1});
    endtask

    task automatic cyc(logic [NS-1:0] raw, bit cw, int ci, logic [3:0] cd,
                       bit sv, logic [1:0] so, int si, string tag);
        @(negedge clk);
        src_raw = raw; cfg_we = cw; cfg_idx = IW'(ci); cfg_data = cd;
        sw_valid = sv; sw_op = so; sw_idx = IW'(si);
        @(posedge clk);
        model_step();
        #1;
        compare_model(tag);
    endtask

    task automatic idle(logic [NS-1:0] raw, string tag);
        cyc(raw, 0, 0, 4'd0, 0, 2'd0, 0, tag);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary();
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        rd_idx = 3'd1;
        #1;
        chk(pend_o == 0 && en_o == 0 && rect_o == 0, "R1 vectors", {pend_o, en_o, rect_o}, 0);
        chk(rd_mode == 0 && !rd_pend && !rd_en, "R1 read", {rd_mode, rd_pend, rd_en}, 0);
        rst = 1'b0;

        rd_idx = 3'd2;
        // R2 detach flag forces inactive, plain write stores mode
        cyc(6'b0, 1, 2, 4'b1100, 0, 0, 0, "R2");
        #1 chk(rd_mode == 3'd0, "R2 detach", rd_mode, 0);
        cyc(6'b0, 1, 2, 4'b0100, 0, 0, 0, "R2");
        #1 chk(rd_mode == 3'd4, "R2 rise stored", rd_mode, 4);

        // R3 rising edge
        cyc(6'b000100, 0, 0, 0, 0, 0, 0, "R3");
        chk(pend_o[2] == 1, "R3 edge sets", pend_o[2], 1);
        cyc(6'b000100, 0, 0, 0, 1, 2'd1, 2, "R3");
        idle(6'b000100, "R3");
        chk(pend_o[2] == 0, "R3 held level no re-set", pend_o[2], 0);

        // R4 falling edge, R7 inverted rectify
        cyc(6'b000100, 1, 2, 4'b0101, 0, 0, 0, "R4");
        cyc(6'b000000, 0, 0, 0, 0, 0, 0, "R4");
        chk(pend_o[2] == 1, "R4 fall sets", pend_o[2], 1);
        chk(rect_o[2] == 1, "R7 fall rect", rect_o[2], 1);

        // R5 level high, R10 same-cycle clear wins
        cyc(6'b000100, 1, 2, 4'b0110, 1, 2'd1, 2, "R5");
        idle(6'b000100, "R5");
        chk(pend_o[2] == 1, "R5 high sets", pend_o[2], 1);
        cyc(6'b000100, 0, 0, 0, 1, 2'd1, 2, "R10");
        chk(pend_o[2] == 0, "R10 clear after input", pend_o[2], 0);
        idle(6'b000100, "R5");
        chk(pend_o[2] == 1, "R5 level re-sets", pend_o[2], 1);
        cyc(6'b000100, 1, 2, 4'b0111, 1, 2'd1, 2, "R5");
        cyc(6'b000000, 0, 0, 0, 0, 0, 0, "R5");
        chk(pend_o[2] == 1, "R5 low sets", pend_o[2], 1);

        // R8 filtering: level low with raw 1 drops a set
        cyc(6'b000100, 0, 0, 0, 1, 2'd1, 2, "R8");
        cyc(6'b000100, 0, 0, 0, 1, 2'd0, 2, "R8");
        chk(pend_o[2] == 0, "R8 level set dropped", pend_o[2], 0);
        cyc(6'b000100, 1, 2, 4'b0000, 0, 0, 0, "R8");
        cyc(6'b000000, 0, 0, 0, 1, 2'd0, 2, "R8");
        chk(pend_o[2] == 0, "R8 inactive ignores set", pend_o[2], 0);
        cyc(6'b000000, 1, 2, 4'b0100, 0, 0, 0, "R8");
        cyc(6'b000000, 0, 0, 0, 1, 2'd0, 2, "R8");
        chk(pend_o[2] == 1, "R8 edge accepts set", pend_o[2], 1);

        // R9 invalid indices
        cyc(6'b0, 0, 0, 0, 1, 2'd2, 0, "R9");
        cyc(6'b0, 0, 0, 0, 1, 2'd2, 6, "R9");
        cyc(6'b0, 0, 0, 0, 1, 2'd2, 7, "R9");
        chk(en_o == 0, "R9 invalid enable writes", en_o, 0);
        rd_idx = 3'd7;
        #1 chk(rd_mode == 0 && !rd_pend && !rd_rect, "R9 read idx7", {rd_mode, rd_pend, rd_rect}, 0);
        rd_idx = 3'd2;

        // R11 enable
        cyc(6'b0, 0, 0, 0, 1, 2'd2, 3, "R11");
        chk(en_o[3] == 1, "R11 set", en_o[3], 1);
        cyc(6'b0, 0, 0, 0, 1, 2'd3, 3, "R11");
        chk(en_o[3] == 0, "R11 clear", en_o[3], 0);

        // R12 detached ignores input, R6 level still tracked
        cyc(6'b0, 0, 0, 0, 1, 2'd1, 2, "R12");
        cyc(6'b0, 1, 2, 4'b0001, 0, 0, 0, "R12");
        idle(6'b000100, "R12");
        idle(6'b000000, "R12");
        idle(6'b000100, "R12");
        chk(pend_o[2] == 0 && rect_o[2] == 0, "R12 detached quiet", {pend_o[2], rect_o[2]}, 0);
        cyc(6'b000100, 1, 2, 4'b0100, 0, 0, 0, "R6");
        idle(6'b000100, "R6");
        chk(pend_o[2] == 0, "R6 stored level blocks edge", pend_o[2], 0);
        chk(rect_o[2] == 1, "R6 stored level visible", rect_o[2], 1);

        // R10 edge with same-cycle clear
        idle(6'b000000, "R10");
        cyc(6'b000100, 0, 0, 0, 1, 2'd1, 2, "R10");
        chk(pend_o[2] == 0, "R10 edge then clear", pend_o[2], 0);

        // random phase, R3 R4 R5 R8 against the model
        void'($urandom(32'h1d2c));
        for (int n = 0; n < 3000; n++) begin
            logic [NS-1:0] flip;
            flip = '0;
            for (int b = 1; b < NS; b++) flip[b] = ($urandom % 4) == 0;
            rd_idx = IW'($urandom % 8);
            cyc(src_raw ^ flip, ($urandom % 10) == 0, $urandom % 8, 4'($urandom),
                ($urandom % 3) == 0, 2'($urandom), $urandom % 8, "R3 R4 R5 R8 random");
        end

        finished = 1;
        summary();
    end
endmodule